// File: doc/BRIEF.md
# Stack push address and data unit

This unit performs the stack-write step of a push micro-operation in a CPU that runs in real, protected (16/32-bit) and 64-bit modes. It takes the current stack pointer, the mode, a stack-address-size flag, the effective operand size, a source kind and the source value. From these it computes the updated stack pointer, the memory write address, the write data with byte enables, and two fault indications.

The pointer width comes from the mode and the stack-address-size flag. The decrement amount comes from the operand size. Immediates are sign-extended to the operand size. Segment selectors are zero-extended, or stored as a two-byte write under a 32-bit operand size. A push of the stack pointer stores its value from before the update. A request is accepted when `req_valid_i` and `req_ready_o` are both high. All results are registered and appear for one cycle, marked by `done_o`, on the cycle after acceptance.

Top module: `stack_push_unit`

## Requirements
- R1: The pointer is decremented by 2, 4 or 8 for operand size code 0 (16-bit), 1 (32-bit) or 2 (64-bit). `wr_addr_o` equals the decremented pointer, restricted to the stack width.
- R2: The stack width is 64 bits when `mode_i`=2 (64-bit mode). In any other mode it is 32 bits when `stk32_i`=1 and 16 bits when `stk32_i`=0. Pointer bits above the stack width pass to `sp_o` unchanged, and the decrement wraps within the width. `wr_addr_o` is zero above the width.
- R3: A push narrower than the stack width may leave the pointer misaligned (for example 0x1000 becomes 0xFFE). This raises no fault.
- R4: An immediate source (`src_kind_i`=1) is taken from the low 8, 16 or 32 bits of `src_val_i` for `imm_w_i` = 0, 1 or 2; code 3 means 32 bits. It is sign-extended to 64 bits, and bytes beyond the operand size are written as zero.
- R5: A segment source (`src_kind_i`=2) writes `src_val_i[15:0]` zero-extended. With a 64-bit operand the byte enables are 0xFF. With a 16- or 32-bit operand they are 0x03, so a 32-bit push leaves the upper two bytes at that location unmodified. `wr_be_o` has bit n for byte n of `wr_data_o`.
- R6: A register source (`src_kind_i`=0) writes `src_val_i` truncated to the operand size. When `src_is_sp_i`=1, it writes `sp_i`, the pointer from before the decrement, truncated to the operand size.
- R7: A memory source (`src_kind_i`=3) writes `src_val_i` truncated to the operand size. The enables are 0x03, 0x0F or 0xFF for 2, 4 or 8 bytes.
- R8: In real mode (`mode_i`=0), if the pointer restricted to the stack width equals 1, `ss_fault_o` is raised, `wr_en_o` stays low and `sp_o` equals `sp_i`.
- R9: `ud_fault_o` is raised in any of these cases:
  - operand code 3;
  - a 32-bit operand in 64-bit mode;
  - a 64-bit operand outside 64-bit mode;
  - a segment push in 64-bit mode with `seg_id_i` below 4 (0 ES, 1 CS, 2 SS, 3 DS). Codes 4 (FS) and 5 (GS) are allowed.

  When `ud_fault_o` is raised there is no write, `sp_o` equals `sp_i`, and `ss_fault_o` stays low.
- R10: After reset:
  - `req_ready_o` is high;
  - `done_o`, `wr_en_o`, both fault outputs, `wr_be_o` and `sp_o` are zero;
  - an accepted request gives `done_o` high exactly one cycle later;
  - in a cycle with no result, `done_o` and `wr_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Push request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| mode_i | input | 2 | 0 real, 1 protected, 2 64-bit, 3 treated as protected |
| stk32_i | input | 1 | Stack-address-size flag outside 64-bit mode |
| opsz_i | input | 2 | Operand size: 0 16-bit, 1 32-bit, 2 64-bit, 3 invalid |
| src_kind_i | input | 2 | 0 register, 1 immediate, 2 segment, 3 memory value |
| imm_w_i | input | 2 | Immediate width: 0 8-bit, 1 16-bit, 2/3 32-bit |
| seg_id_i | input | 3 | Segment code: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| src_is_sp_i | input | 1 | Register source is the stack pointer |
| sp_i | input | 64 | Current stack pointer |
| src_val_i | input | 64 | Source value |
| done_o | output | 1 | Result valid, one cycle after acceptance |
| sp_o | output | 64 | Updated stack pointer |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 64 | Memory write address |
| wr_data_o | output | 64 | Write data, byte 0 at the address |
| wr_be_o | output | 8 | Byte enables |
| ss_fault_o | output | 1 | Stack-segment limit fault |
| ud_fault_o | output | 1 | Invalid-operation fault |

## Verification
Every result of this unit is registered once. The pointer, address, data, enables and both faults for a request accepted at one rising edge are therefore due at the next rising edge, and `done_o` drops again one edge later if no new request follows. The bench drives each request on a falling edge and samples all outputs on the following falling edge, halfway between the capturing edge and the next one. It compares them against a bench reference model. One extra idle sample after an operation confirms that `done_o` and `wr_en_o` have cleared.

// File: rtl/stack_push_pkg.sv
package stack_push_pkg;
  localparam int unsigned XLEN = 64;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_LONG = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OP16  = 2'd0,
    OP32  = 2'd1,
    OP64  = 2'd2,
    OPRSV = 2'd3
  } opsz_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_IMM = 2'd1,
    SRC_SEG = 2'd2,
    SRC_MEM = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    IMM8   = 2'd0,
    IMM16  = 2'd1,
    IMM32  = 2'd2,
    IMM32B = 2'd3
  } imm_e;

  // segment codes below this value are legacy-only
  localparam logic [2:0] SEG_FIRST_LONG_OK = 3'd4;
endpackage

// File: rtl/spu_addr.sv
module spu_addr
  import stack_push_pkg::*;
#(
  parameter int unsigned XW = XLEN
) (
  input  mode_e           mode_i,
  input  logic            stk32_i,
  input  opsz_e           opsz_i,
  input  logic [XW-1:0]   sp_i,
  output logic [XW-1:0]   sp_new_o,
  output logic [XW-1:0]   addr_o,
  output logic            sp_one_o
);
  logic [XW-1:0] dec, width_mask, diff;

  always_comb begin
    unique case (opsz_i)
      OP16:    dec = XW'(2);
      OP32:    dec = XW'(4);
      default: dec = XW'(8);
    endcase
    if (mode_i == MODE_LONG)
      width_mask = '1;
    else if (stk32_i)
      width_mask = {{(XW-32){1'b0}}, {32{1'b1}}};
    else
      width_mask = {{(XW-16){1'b0}}, {16{1'b1}}};
    diff     = sp_i - dec;
    sp_new_o = (sp_i & ~width_mask) | (diff & width_mask);
    addr_o   = diff & width_mask;
    sp_one_o = ((sp_i & width_mask) == XW'(1));
  end
endmodule

// File: rtl/spu_data.sv
module spu_data
  import stack_push_pkg::*;
#(
  parameter int unsigned XW = XLEN,
  localparam int unsigned NB = XW / 8
) (
  input  opsz_e           opsz_i,
  input  src_e            src_kind_i,
  input  imm_e            imm_w_i,
  input  logic            src_is_sp_i,
  input  logic [XW-1:0]   sp_i,
  input  logic [XW-1:0]   src_val_i,
  output logic [XW-1:0]   data_o,
  output logic [NB-1:0]   be_o
);
  logic [XW-1:0] raw, byte_mask;
  int unsigned   nbytes;

  always_comb begin
    unique case (src_kind_i)
      SRC_REG: raw = src_is_sp_i ? sp_i : src_val_i;
      SRC_IMM: begin
        unique case (imm_w_i)
          IMM8:    raw = {{(XW-8){src_val_i[7]}}, src_val_i[7:0]};
          IMM16:   raw = {{(XW-16){src_val_i[15]}}, src_val_i[15:0]};
          default: raw = {{(XW-32){src_val_i[31]}}, src_val_i[31:0]};
        endcase
      end
      SRC_SEG: raw = {{(XW-16){1'b0}}, src_val_i[15:0]};
      default: raw = src_val_i;
    endcase

    unique case (opsz_i)
      OP16:    nbytes = 2;
      OP32:    nbytes = 4;
      default: nbytes = NB;
    endcase
    // selector under a 32-bit operand: two-byte store only
    if (src_kind_i == SRC_SEG && opsz_i == OP32) nbytes = 2;
    be_o = NB'((64'd1 << nbytes) - 64'd1);
  end

  for (genvar b = 0; b < NB; b++) begin : g_bmask
    assign byte_mask[8*b +: 8] = {8{be_o[b]}};
  end

  assign data_o = raw & byte_mask;
endmodule

// File: rtl/spu_check.sv
module spu_check
  import stack_push_pkg::*;
(
  input  mode_e       mode_i,
  input  opsz_e       opsz_i,
  input  src_e        src_kind_i,
  input  logic [2:0]  seg_id_i,
  input  logic        sp_one_i,
  output logic        ss_fault_o,
  output logic        ud_fault_o
);
  logic is_long;

  always_comb begin
    is_long    = (mode_i == MODE_LONG);
    ud_fault_o = (opsz_i == OPRSV)
               | (is_long  & (opsz_i == OP32))
               | (!is_long & (opsz_i == OP64))
               | (is_long  & (src_kind_i == SRC_SEG) & (seg_id_i < SEG_FIRST_LONG_OK));
    ss_fault_o = !ud_fault_o & (mode_i == MODE_REAL) & sp_one_i;
  end
endmodule

// File: rtl/stack_push_unit.sv
module stack_push_unit
  import stack_push_pkg::*;
#(
  parameter int unsigned XW = XLEN,
  localparam int unsigned NB = XW / 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic [1:0]     mode_i,
  input  logic           stk32_i,
  input  logic [1:0]     opsz_i,
  input  logic [1:0]     src_kind_i,
  input  logic [1:0]     imm_w_i,
  input  logic [2:0]     seg_id_i,
  input  logic           src_is_sp_i,
  input  logic [XW-1:0]  sp_i,
  input  logic [XW-1:0]  src_val_i,
  output logic           done_o,
  output logic [XW-1:0]  sp_o,
  output logic           wr_en_o,
  output logic [XW-1:0]  wr_addr_o,
  output logic [XW-1:0]  wr_data_o,
  output logic [NB-1:0]  wr_be_o,
  output logic           ss_fault_o,
  output logic           ud_fault_o
);
  mode_e mode;
  opsz_e opsz;
  src_e  kind;
  imm_e  immw;

  assign mode = mode_e'(mode_i);
  assign opsz = opsz_e'(opsz_i);
  assign kind = src_e'(src_kind_i);
  assign immw = imm_e'(imm_w_i);

  logic [XW-1:0] sp_new, addr, data;
  logic [NB-1:0] be;
  logic          sp_one, ss_f, ud_f, fault, accept;
  logic          ready_q;

  spu_addr #(.XW(XW)) u_addr (
    .mode_i   (mode),
    .stk32_i  (stk32_i),
    .opsz_i   (opsz),
    .sp_i     (sp_i),
    .sp_new_o (sp_new),
    .addr_o   (addr),
    .sp_one_o (sp_one)
  );

  spu_data #(.XW(XW)) u_data (
    .opsz_i      (opsz),
    .src_kind_i  (kind),
    .imm_w_i     (immw),
    .src_is_sp_i (src_is_sp_i),
    .sp_i        (sp_i),
    .src_val_i   (src_val_i),
    .data_o      (data),
    .be_o        (be)
  );

  spu_check u_check (
    .mode_i     (mode),
    .opsz_i     (opsz),
    .src_kind_i (kind),
    .seg_id_i   (seg_id_i),
    .sp_one_i   (sp_one),
    .ss_fault_o (ss_f),
    .ud_fault_o (ud_f)
  );

  assign fault       = ss_f | ud_f;
  assign accept      = req_valid_i & ready_q;
  assign req_ready_o = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q    <= 1'b0;
      done_o     <= 1'b0;
      sp_o       <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      wr_be_o    <= '0;
      ss_fault_o <= 1'b0;
      ud_fault_o <= 1'b0;
    end else begin
      ready_q    <= 1'b1;
      done_o     <= accept;
      wr_en_o    <= accept & ~fault;
      ss_fault_o <= accept & ss_f;
      ud_fault_o <= accept & ud_f;
      wr_be_o    <= (accept & ~fault) ? be : '0;
      if (accept) begin
        sp_o      <= fault ? sp_i : sp_new;
        wr_addr_o <= addr;
        wr_data_o <= data;
      end
    end
  end

  assert_done_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_valid_i & req_ready_o));

  assert_idle_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !wr_en_o && wr_be_o == '0);

  assert_fault_no_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (ss_fault_o || ud_fault_o)) |-> (!wr_en_o && sp_o == $past(sp_i)));

  assert_ud_masks_ss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ud_fault_o |-> !ss_fault_o);

  assert_ss_real_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_fault_o |-> $past(mode_i) == MODE_REAL);

  assert_upper_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(mode_i) != MODE_LONG && !$past(stk32_i))
      |-> sp_o[XW-1:16] == $past(sp_i[XW-1:16]));

  assert_addr_is_sp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(mode_i) == MODE_LONG) |-> wr_addr_o == sp_o);

  assert_be_shape_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_be_o == NB'(8'h03) || wr_be_o == NB'(8'h0F) || wr_be_o == NB'(8'hFF)));
endmodule

// File: tb/stack_push_unit_tb_top.sv
`timescale 1ns/1ps
module stack_push_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [1:0]  mode = 2'd0, opsz = 2'd0, kind = 2'd0, immw = 2'd0;
  logic        stk32 = 1'b0, is_sp = 1'b0;
  logic [2:0]  seg = 3'd0;
  logic [63:0] sp = '0, val = '0;
  logic        done, wr_en, ss_f, ud_f;
  logic [63:0] sp_out, addr, data;
  logic [7:0]  be;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stack_push_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .mode_i(mode), .stk32_i(stk32), .opsz_i(opsz), .src_kind_i(kind),
    .imm_w_i(immw), .seg_id_i(seg), .src_is_sp_i(is_sp), .sp_i(sp),
    .src_val_i(val), .done_o(done), .sp_o(sp_out), .wr_en_o(wr_en),
    .wr_addr_o(addr), .wr_data_o(data), .wr_be_o(be),
    .ss_fault_o(ss_f), .ud_fault_o(ud_f)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // expected results derived from the requirements
  task automatic expect_op(output logic [63:0] e_sp, e_addr, e_data,
                           output logic [7:0] e_be, output logic e_wr, e_ss, e_ud);
    int w, n, bytes;
    logic [63:0] lw, low, v;
    w  = (mode == 2) ? 64 : (stk32 ? 32 : 16);
    n  = (opsz == 0) ? 2 : (opsz == 1) ? 4 : 8;
    lw = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    e_ud = (opsz == 3) || (mode == 2 && opsz == 1) || (mode != 2 && opsz == 2)
           || (mode == 2 && kind == 2 && seg < 4);
    e_ss = !e_ud && mode == 0 && ((sp & lw) == 64'd1);
    low  = ((sp & lw) - 64'(n)) & lw;
    e_addr = low;
    case (kind)
      2'd0: v = is_sp ? sp : val;
      2'd1: v = (immw == 0) ? 64'($signed(val[7:0])) :
                (immw == 1) ? 64'($signed(val[15:0])) : 64'($signed(val[31:0]));
      2'd2: v = {48'd0, val[15:0]};
      default: v = val;
    endcase
    bytes  = (kind == 2 && opsz == 1) ? 2 : n;
    e_data = v & ((bytes == 8) ? '1 : ((64'd1 << (8 * bytes)) - 64'd1));
    if (e_ud || e_ss) begin
      e_sp = sp; e_wr = 0; e_be = 8'h00;
    end else begin
      e_sp = (sp & ~lw) | low; e_wr = 1; e_be = 8'((16'd1 << bytes) - 16'd1);
    end
  endtask

  task automatic run_op(string tag, logic [1:0] m, logic s32, logic [1:0] o,
                        logic [1:0] k, logic [1:0] iw, logic [2:0] sg,
                        logic isp, logic [63:0] p, logic [63:0] v);
    logic [63:0] e_sp, e_addr, e_data;
    logic [7:0]  e_be;
    logic        e_wr, e_ss, e_ud;
    @(negedge clk);
    mode = m; stk32 = s32; opsz = o; kind = k; immw = iw; seg = sg;
    is_sp = isp; sp = p; val = v; valid = 1'b1;
    expect_op(e_sp, e_addr, e_data, e_be, e_wr, e_ss, e_ud);
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " done"}, 64'(done), 64'd1);
    chk({tag, " sp"}, sp_out, e_sp);
    chk({tag, " wr_en"}, 64'(wr_en), 64'(e_wr));
    chk({tag, " be"}, 64'(be), 64'(e_be));
    chk({tag, " ss"}, 64'(ss_f), 64'(e_ss));
    chk({tag, " ud"}, 64'(ud_f), 64'(e_ud));
    if (e_wr) begin
      chk({tag, " addr"}, addr, e_addr);
      chk({tag, " data"}, data, e_data);
    end
  endtask

  initial begin
    #(4 * 190000);
    errs++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R10 reset wr_en", 64'(wr_en), 64'd0);
    chk("R10 reset sp", sp_out, 64'd0);
    chk("R10 reset be", 64'(be), 64'd0);
    chk("R10 reset faults", 64'({ss_f, ud_f}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 ready", 64'(ready), 64'd1);

    run_op("R1 op32", 2'd1, 1'b1, 2'd1, 2'd0, 2'd0, 3'd0, 1'b0, 64'h1000, 64'h1122_3344_5566_7788);
    run_op("R1 op64", 2'd2, 1'b0, 2'd2, 2'd0, 2'd0, 3'd0, 1'b0, 64'h8000_0000_0000_0010, 64'hCAFE);
    run_op("R2 wrap16", 2'd1, 1'b0, 2'd0, 2'd3, 2'd0, 3'd0, 1'b0, 64'hAAAA_BBBB_CCCC_0000, 64'h1234);
    run_op("R2 wrap32", 2'd0, 1'b1, 2'd1, 2'd3, 2'd0, 3'd0, 1'b0, 64'h1234_5678_0000_0002, 64'hFFFF_FFFF);
    run_op("R3 misalign", 2'd2, 1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 64'h1000, 64'hBEEF);
    run_op("R4 imm8neg", 2'd2, 1'b0, 2'd2, 2'd1, 2'd0, 3'd0, 1'b0, 64'h4000, 64'h55AA_0080);
    run_op("R4 imm8pos", 2'd1, 1'b0, 2'd0, 2'd1, 2'd0, 3'd0, 1'b0, 64'h4000, 64'hFFFF_FF7F);
    run_op("R4 imm16", 2'd1, 1'b1, 2'd1, 2'd1, 2'd1, 3'd0, 1'b0, 64'h4000, 64'h0000_8001);
    run_op("R4 imm32", 2'd2, 1'b0, 2'd2, 2'd1, 2'd2, 3'd0, 1'b0, 64'h4000, 64'h9000_0001);
    run_op("R5 seg32", 2'd1, 1'b1, 2'd1, 2'd2, 2'd0, 3'd1, 1'b0, 64'h2000, 64'hDEAD_BEEF_1234_5678);
    run_op("R5 seg64fs", 2'd2, 1'b0, 2'd2, 2'd2, 2'd0, 3'd4, 1'b0, 64'h2000, 64'hDEAD_BEEF_1234_5678);
    run_op("R5 seg16", 2'd0, 1'b0, 2'd0, 2'd2, 2'd0, 3'd2, 1'b0, 64'h2000, 64'hFFFF_ABCD);
    run_op("R6 pushsp", 2'd2, 1'b0, 2'd2, 2'd0, 2'd0, 3'd0, 1'b1, 64'h0000_7FFF_0000_2000, 64'h0);
    run_op("R6 reg16", 2'd1, 1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 64'h200, 64'h1111_2222_3333_4444);
    run_op("R7 mem32", 2'd1, 1'b1, 2'd1, 2'd3, 2'd0, 3'd0, 1'b0, 64'h3000, 64'h9999_8888_7777_6666);
    run_op("R8 sp1", 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 64'h1, 64'h55);
    run_op("R8 sp1hi", 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 64'h0001_0001, 64'h55);
    run_op("R8 sp2ok", 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 64'h2, 64'h55);
    run_op("R8 prot1", 2'd1, 1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 64'h1, 64'h55);
    run_op("R9 cs64", 2'd2, 1'b0, 2'd2, 2'd2, 2'd0, 3'd1, 1'b0, 64'h5000, 64'h8);
    run_op("R9 gs64", 2'd2, 1'b0, 2'd2, 2'd2, 2'd0, 3'd5, 1'b0, 64'h5000, 64'h8);
    run_op("R9 op32long", 2'd2, 1'b0, 2'd1, 2'd0, 2'd0, 3'd0, 1'b0, 64'h5000, 64'h8);
    run_op("R9 op64prot", 2'd1, 1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 1'b0, 64'h5000, 64'h8);
    run_op("R9 oprsv", 2'd0, 1'b0, 2'd3, 2'd0, 2'd0, 3'd0, 1'b0, 64'h1, 64'h8);
    @(negedge clk);
    chk("R10 idle done", 64'(done), 64'd0);
    chk("R10 idle wr_en", 64'(wr_en), 64'd0);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] rp, rv;
      logic [1:0]  rm;
      rm = 2'($urandom_range(0, 2));
      rp = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) rp[15:0] = 16'd1;
      rv = {$urandom, $urandom};
      run_op("R1 R6 random", rm, 1'($urandom), 2'($urandom), 2'($urandom),
             2'($urandom), 3'($urandom_range(0, 5)), 1'($urandom), rp, rv);
    end
    finish_run();
  end
endmodule